// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block moves 18-bit words between two buses, called A and B, in both directions at once. Each direction has its own storage cell and three controls: a latch enable, a capture clock and an output enable. When the latch enable is high, the far-side output follows the near-side input with no register in the path. When the latch enable is low, the output shows the stored word. That word is replaced only when the capture clock for the direction rises. The two output enables have opposite polarities. The A-to-B enable is active high and the B-to-A enable is active low.

Each pad is modelled as a data output with a drive enable instead of a tri-state net, so the block stays synthesizable inside a larger chip. The capture clocks are treated as level inputs. A system clock `clk` samples them, and a rising edge is detected when one sample is high and the sample before it was low. Each level of a capture clock must therefore last at least one `clk` period.

Both outputs are plain data with a drive qualifier. The drive enable acts as the valid indication. There is no ready input, because a bus cannot push back: a driven word is on the bus whether or not anyone reads it.

Top module: `xcvr_bidir`

## Requirements
- R1: While `le_ab` is 1, `b_out` equals `a_in` in the same cycle, with no register in the path.
- R2: While `le_ab` is 0, the `clk` edge that first samples `clk_ab` high after a low sample stores `a_in`. The stored word appears on `b_out` right after that edge.
- R3: While `le_ab` is 0 and no rising edge of `clk_ab` is detected, `b_out` keeps the stored word even when `a_in` changes, and also when `clk_ab` falls.
- R4: While `le_ab` is 1, the storage cell loads `a_in` at every `clk` edge. After `le_ab` falls, `b_out` shows the `a_in` value sampled at the last `clk` edge that saw `le_ab` high.
- R5: A rising edge of `clk_ab` while `le_ab` is 1 has no effect beyond the transparent behaviour: `b_out` still equals `a_in`.
- R6: `b_drive` is 1 exactly when `rst_n` is 1 and `oe_ab` is 1 (active-high enable).
- R7: `a_drive` is 1 exactly when `rst_n` is 1 and `oe_ba_n` is 0 (active-low enable).
- R8: The B-to-A direction behaves as described in R1 to R5, using `le_ba`, `clk_ba`, `b_in` and `a_out`.
- R9: While `rst_n` is 0, both storage cells are cleared to zero, both drive enables are 0, and the edge detectors take a high level as their previous sample. A capture clock that is already high when reset is released therefore causes no capture.
- R10: All 18 bits of a direction share its controls, so every bit pattern moves whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the capture clocks and updates storage |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 18 | Word received from the A bus |
| b_in | input | 18 | Word received from the B bus |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| clk_ab | input | 1 | A-to-B capture clock (level, sampled) |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| clk_ba | input | 1 | B-to-A capture clock (level, sampled) |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word driven onto the B bus |
| b_drive | output | 1 | B bus drive enable (0 = high impedance) |
| a_out | output | 18 | Word driven onto the A bus |
| a_drive | output | 1 | A bus drive enable (0 = high impedance) |

## Verification
Results fall into three timing groups:
- **Same cycle:** transparent data and both drive enables are due in the same cycle as their inputs, because no register lies in their path.
- **Next edge:** a captured word, and the word held after a latch-enable fall, become due just after the first `clk` edge that samples the stimulus.
- **Asynchronous:** reset clears the outputs at once, without waiting for a clock edge.

The bench drives inputs just after the falling edge of `clk` and compares every output against its reference model one time unit later, which is before the next rising edge. It advances the model's stored words and edge history only at the rising edge, so each comparison sees exactly one storage update.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int BUS_W = 18;

  typedef struct packed {
    logic le;
    logic cap_clk;
    logic oe;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = xcvr_pkg::BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic load;
  assign load = le | cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && cap) |=> (q == $past(d))); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !cap) |=> $stable(q)); // R3
  AST_TRACK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (q == $past(d))); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0)); // R9
endmodule

// File: rtl/xcvr_oe.sv
module xcvr_oe #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic rst_n,
  input  logic oe,
  output logic drive
);
  logic en;
  generate
    if (ACTIVE_LOW) begin : g_low
      assign en = ~oe;
    end else begin : g_high
      assign en = oe;
    end
  endgenerate

  assign drive = rst_n & en;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W          = xcvr_pkg::BUS_W,
  parameter bit OE_ACT_LOW = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  xcvr_pkg::lane_ctrl_t   ctrl,
  input  logic [W-1:0]           din,
  output logic [W-1:0]           dout,
  output logic                   drive
);
  logic         cap;
  logic [W-1:0] held;

  xcvr_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ctrl.cap_clk),
    .rise  (cap)
  );

  xcvr_store #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (ctrl.le),
    .cap   (cap),
    .d     (din),
    .q     (held)
  );

  xcvr_oe #(.ACTIVE_LOW(OE_ACT_LOW)) u_oe (
    .rst_n (rst_n),
    .oe    (ctrl.oe),
    .drive (drive)
  );

  assign dout = ctrl.le ? din : held;

  AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.le |-> (dout == din)); // R1
  AST_CLOSED_SHOWS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.le && $past(!ctrl.le) && !$past(cap)) |-> $stable(dout)); // R3
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
  parameter int W = xcvr_pkg::BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         le_ab,
  input  logic         clk_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         clk_ba,
  input  logic         oe_ba_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  localparam int NDIR = 2;

  xcvr_pkg::lane_ctrl_t ctrl [NDIR];
  logic [W-1:0]         din  [NDIR];
  logic [W-1:0]         dout [NDIR];
  logic                 drv  [NDIR];

  assign ctrl[0] = '{le: le_ab, cap_clk: clk_ab, oe: oe_ab};
  assign ctrl[1] = '{le: le_ba, cap_clk: clk_ba, oe: oe_ba_n};
  assign din[0]  = a_in;
  assign din[1]  = b_in;

  generate
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
      xcvr_lane #(.W(W), .OE_ACT_LOW(g == 1)) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl[g]),
        .din   (din[g]),
        .dout  (dout[g]),
        .drive (drv[g])
      );
    end
  endgenerate

  assign b_out   = dout[0];
  assign b_drive = drv[0];
  assign a_out   = dout[1];
  assign a_drive = drv[1];

  AST_AB_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    b_drive == oe_ab); // R6
  AST_BA_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    a_drive == !oe_ba_n); // R7
  AST_BA_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    le_ba |-> (a_out == b_in)); // R8
endmodule

// File: tb/test_xcvr_bidir.sv
module test_xcvr_bidir;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic le_ab = 0, clk_ab = 0, oe_ab = 0;
  logic le_ba = 0, clk_ba = 0, oe_ba_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_ab, m_ba;
  logic p_ab, p_ba;

  always #2 clk = ~clk;

  xcvr_bidir i_xcvr_bidir (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .le_ab(le_ab), .clk_ab(clk_ab), .oe_ab(oe_ab),
    .le_ba(le_ba), .clk_ba(clk_ba), .oe_ba_n(oe_ba_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called just after a falling edge with inputs already set
  task automatic cyc(input string tag);
    logic [W-1:0] eb, ea;
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; p_ab = 1'b1; p_ba = 1'b1;
    end
    #1;
    eb = le_ab ? a_in : m_ab;
    ea = le_ba ? b_in : m_ba;
    chk(tag, "b_out", b_out, eb);
    chk(tag, "a_out", a_out, ea);
    chk(tag, "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, rst_n & oe_ab});
    chk(tag, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, rst_n & ~oe_ba_n});
    @(posedge clk);
    if (rst_n) begin
      if (le_ab || (clk_ab && !p_ab)) m_ab = a_in;
      if (le_ba || (clk_ba && !p_ba)) m_ba = b_in;
      p_ab = clk_ab;
      p_ba = clk_ba;
    end
    @(negedge clk);
  endtask

  initial begin
    m_ab = '0; m_ba = '0; p_ab = 1'b1; p_ba = 1'b1;
    @(negedge clk);
    // R9: reset clears storage and disables drivers
    a_in = 18'h2AAAA; b_in = 18'h15555; oe_ab = 1; oe_ba_n = 0;
    cyc("R9"); cyc("R9");
    clk_ab = 1; clk_ba = 1; rst_n = 1;
    cyc("R9"); cyc("R9");
    // R6 / R7: enable polarities
    oe_ab = 0; oe_ba_n = 1; cyc("R6");
    oe_ab = 1; oe_ba_n = 1; cyc("R6");
    oe_ab = 0; oe_ba_n = 0; cyc("R7");
    oe_ab = 1; cyc("R7");
    // R2: capture on rising clk_ab
    clk_ab = 0; a_in = 18'h0F0F0; cyc("R3");
    clk_ab = 1; a_in = 18'h12345; cyc("R2");
    a_in = 18'h3FFFF; cyc("R2");
    // R3: clock held high, then falling, no capture
    a_in = 18'h00001; cyc("R3");
    clk_ab = 0; a_in = 18'h20000; cyc("R3");
    a_in = 18'h11111; cyc("R3");
    // R1 / R5: transparent, clock edges ignored
    le_ab = 1; a_in = 18'h0ABCD; cyc("R1");
    a_in = 18'h3C3C3; clk_ab = 1; cyc("R5");
    a_in = 18'h05A5A; clk_ab = 0; cyc("R5");
    a_in = 18'h2468A; cyc("R1");
    // R4: latch enable falls, last sampled value held
    le_ab = 0; a_in = 18'h39999; cyc("R4");
    a_in = 18'h00000; cyc("R4");
    // R8: reverse direction
    le_ba = 1; b_in = 18'h1357B; cyc("R8");
    b_in = 18'h2BCDE; cyc("R8");
    le_ba = 0; b_in = 18'h0000F; cyc("R8");
    clk_ba = 0; cyc("R8");
    clk_ba = 1; b_in = 18'h30303; cyc("R8");
    b_in = 18'h1FFFF; cyc("R8");
    // R10: whole-word patterns
    a_in = 18'h3FFFF; b_in = 18'h00000; le_ab = 1; le_ba = 1; cyc("R10");
    a_in = 18'h15555; b_in = 18'h2AAAA; cyc("R10");
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      le_ab = ($urandom % 4) == 0; le_ba = ($urandom % 4) == 0;
      clk_ab = $urandom % 2; clk_ba = $urandom % 2;
      oe_ab = $urandom % 2; oe_ba_n = $urandom % 2;
      cyc("R10");
    end
    // R9: asynchronous reset mid-run
    rst_n = 0; cyc("R9");
    rst_n = 1; le_ab = 0; le_ba = 0; clk_ab = 0; clk_ba = 0; cyc("R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule